// File: doc/BRIEF.md
# Bus Request/Grant Handshake Controller

This block sits on the bus-owner side of a processor's external memory bus. It lets an outside master borrow that bus. The outside master drives an active-low request line that has no timing relation to the local clock. The controller passes that line through a synchroniser and waits until the current external access is over. It then turns off the output enables of every memory-select strobe and of the read and write strobes. After a one-cycle sequencing step it drives the active-low grant low.

While the bus is lent out, the core may need the external bus to go on. In that case the controller stalls the core and drives a separate active-low hung-grant flag. That flag tells the borrowing master that the processor is waiting on the bus it gave away. When the request line goes high again, the controller first releases the grant. One cycle later it drives the strobes again. The core stall stays up for one more cycle after the strobes return, so that the first access after reclaim sees a bus that has settled.

All strobe, grant and hung-grant outputs come from a registered state. The only exception is the hung-grant flag and the stall, which also depend directly on the core's bus-need input. Pad timing, tri-state drivers and address decoding belong to the surrounding logic.

Top module: `bus_grant_ctrl`

## Requirements
- R1: After reset, `grant_n` and `hung_n` are 1, every bit of `sel_oe`, `rd_oe` and `wr_oe` is 1, and `core_stall` is 0.
- R2: When `ext_req_n` goes low and `xfer_busy` is 0, the strobe enables go to 0 after the third rising edge following the change, and stay 1 after the second.
- R3: `grant_n` goes low exactly one cycle after the strobe enables go to 0. No strobe enable is ever 1 while `grant_n` is 0.
- R4: While `xfer_busy` is 1 in the owned state, the strobes stay driven whatever the request. They are disabled at the first rising edge at which `xfer_busy` is sampled 0 with the request recognised.
- R5: When `ext_req_n` returns high during a grant, `grant_n` goes to 1 after the third rising edge. The strobe enables return to 1 one cycle later, never in the same cycle as the grant release.
- R6: `hung_n` is 0 exactly when the grant is active and `core_need` is 1. It is 1 whenever `grant_n` is 1.
- R7: `core_stall` equals `core_need` whenever the strobes are disabled. It also equals `core_need` in the single cycle just after the strobes come back. Otherwise it is 0.
- R8: A request that is low for only one sampling edge still runs a full cycle: release, a grant at least one cycle long, then reclaim.
- R9: A grant with `core_need` held at 0 never lowers `hung_n` and never raises `core_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| core_need | input | 1 | Core needs the external bus to continue |
| xfer_busy | input | 1 | An external access is in progress and is not in its final cycle |
| sel_oe | output | NUM_SEL (5) | Output enables of the memory-select strobes, 1 = driven |
| rd_oe | output | 1 | Output enable of the read strobe |
| wr_oe | output | 1 | Output enable of the write strobe |
| grant_n | output | 1 | Active-low bus grant |
| hung_n | output | 1 | Active-low hung-grant flag |
| core_stall | output | 1 | Stalls the core while it cannot use the bus |

## Verification
Each result has a fixed latency, counted from the clock edge that first samples a changed input. Request recognition passes through two synchroniser flops and the state register, so the strobe change is due after the third edge. The grant change follows one edge later. On release, the grant change is due after the third edge and the strobes return after the fourth. The stall tail ends one edge after that. Hung-grant and stall follow `core_need` in the same cycle. Each bench task drives its inputs just after a rising edge, counts the edges up to the due one, and samples one time unit after it. The task also checks the value one edge earlier, so a result that comes one cycle too early or too late is caught. A per-cycle monitor checks on every negative edge that no strobe is driven while the grant is low.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic [1:0] {
    ST_OWNED      = 2'd0,
    ST_RELEASING  = 2'd1,
    ST_GRANTED    = 2'd2,
    ST_RECLAIMING = 2'd3
  } bus_state_e;
endpackage

// File: rtl/bgc_req_sync.sv
module bgc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_n,
  output logic req_seen
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= ~req_async_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign req_seen = chain[STAGES-1];

  initial assert (STAGES >= 2) else $error("synchroniser needs two stages");

  // R2: the recognised request is the previous stage delayed by one edge
  assert_sync_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (req_seen == $past(chain[STAGES-2])));
endmodule

// File: rtl/bgc_fsm.sv
module bgc_fsm
  import bgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_seen,
  input  logic       xfer_busy,
  output bus_state_e state
);
  bus_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OWNED:      if (req_seen && !xfer_busy) nxt = ST_RELEASING;
      ST_RELEASING:  nxt = ST_GRANTED;
      ST_GRANTED:    if (!req_seen) nxt = ST_RECLAIMING;
      ST_RECLAIMING: nxt = ST_OWNED;
      default:       nxt = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_OWNED;
    else        state <= nxt;

  // R4: a busy external access keeps the bus owned
  assert_busy_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWNED && xfer_busy) |=> state == ST_OWNED);
  // R3: the release step lasts one cycle and leads to the grant
  assert_release_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RELEASING |=> state == ST_GRANTED);
  // R5: the reclaim step lasts one cycle and leads back to ownership
  assert_reclaim_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RECLAIMING |=> state == ST_OWNED);
endmodule

// File: rtl/bgc_outputs.sv
module bgc_outputs
  import bgc_pkg::*;
#(
  parameter int NUM_SEL = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  bus_state_e         state,
  input  logic               core_need,
  output logic [NUM_SEL-1:0] sel_oe,
  output logic               rd_oe,
  output logic               wr_oe,
  output logic               grant_n,
  output logic               hung_n,
  output logic               core_stall
);
  logic owned;
  logic granted;
  logic settle_tail;

  assign owned   = (state == ST_OWNED);
  assign granted = (state == ST_GRANTED);

  generate
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      assign sel_oe[i] = owned;
    end
  endgenerate

  assign rd_oe   = owned;
  assign wr_oe   = owned;
  assign grant_n = ~granted;
  assign hung_n  = ~(granted & core_need);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) settle_tail <= 1'b0;
    else        settle_tail <= (state == ST_RECLAIMING);

  assign core_stall = core_need & (~owned | settle_tail);

  // R3: no strobe is driven while the grant is active
  assert_no_drive_in_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n |-> (sel_oe == '0 && !rd_oe && !wr_oe));
  // R3: grant falls only after strobes were already off
  assert_grant_after_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> !$past(rd_oe));
  // R5: strobes return only after the grant was already released
  assert_reenable_after_ungrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> $past(grant_n));
  // R6: hung-grant only during a grant
  assert_hung_only_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hung_n |-> !grant_n);
  // R7: a core that does not need the bus is never stalled
  assert_stall_needs_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> core_need);
endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
  import bgc_pkg::*;
#(
  parameter int NUM_SEL     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_req_n,
  input  logic               core_need,
  input  logic               xfer_busy,
  output logic [NUM_SEL-1:0] sel_oe,
  output logic               rd_oe,
  output logic               wr_oe,
  output logic               grant_n,
  output logic               hung_n,
  output logic               core_stall
);
  logic       req_seen;
  bus_state_e state;

  bgc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_async_n(ext_req_n), .req_seen(req_seen)
  );

  bgc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_seen(req_seen), .xfer_busy(xfer_busy),
    .state(state)
  );

  bgc_outputs #(.NUM_SEL(NUM_SEL)) u_out (
    .clk(clk), .rst_n(rst_n), .state(state), .core_need(core_need),
    .sel_oe(sel_oe), .rd_oe(rd_oe), .wr_oe(wr_oe), .grant_n(grant_n),
    .hung_n(hung_n), .core_stall(core_stall)
  );
endmodule

// File: tb/bus_grant_ctrl_bench.sv
`timescale 1ns/1ps
module bus_grant_ctrl_bench;
  localparam int NS = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req_n = 1'b1;
  logic core_need = 1'b0;
  logic xfer_busy = 1'b0;
  logic [NS-1:0] sel_oe;
  logic rd_oe, wr_oe, grant_n, hung_n, core_stall;
  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bus_grant_ctrl u_bus_grant_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .core_need(core_need),
    .xfer_busy(xfer_busy), .sel_oe(sel_oe), .rd_oe(rd_oe), .wr_oe(wr_oe),
    .grant_n(grant_n), .hung_n(hung_n), .core_stall(core_stall)
  );

  function automatic logic [NS+1:0] oe_all();
    return {sel_oe, rd_oe, wr_oe};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  localparam logic [31:0] ON  = {{(32-NS-2){1'b0}}, {(NS+2){1'b1}}};
  localparam logic [31:0] OFF = 32'd0;

  // R3: monitor the no-drive-during-grant rule every cycle
  always @(negedge clk) if (rst_n && !grant_n && oe_all() != '0) begin
    fails++;
    $display("FAIL R3 monitor actual=%0h expected=0", oe_all());
  end

  task automatic t_reset();
    #1;
    chk("R1 oe", oe_all(), ON);
    chk("R1 grant_n", grant_n, 1);
    chk("R1 hung_n", hung_n, 1);
    chk("R1 stall", core_stall, 0);
    edges(2); rst_n = 1'b1; edges(2);
  endtask

  task automatic t_grant_basic();
    ext_req_n = 1'b0;
    edges(2); chk("R2 oe still on", oe_all(), ON);
    edges(1); chk("R2 oe off", oe_all(), OFF);
    chk("R3 grant not yet", grant_n, 1);
    edges(1); chk("R3 grant", grant_n, 0);
    chk("R9 hung_n", hung_n, 1);
    chk("R9 stall", core_stall, 0);
    edges(3); chk("R9 hung_n held", hung_n, 1);
    ext_req_n = 1'b1;
    edges(2); chk("R5 grant held", grant_n, 0);
    edges(1); chk("R5 grant released", grant_n, 1);
    chk("R5 oe still off", oe_all(), OFF);
    edges(1); chk("R5 oe on", oe_all(), ON);
    edges(2);
  endtask

  task automatic t_hung_stall();
    ext_req_n = 1'b0;
    edges(3); core_need = 1'b1; #0;
    #1; chk("R7 stall releasing", core_stall, 1);
    chk("R6 hung_n before grant", hung_n, 1);
    edges(1); chk("R6 hung_n granted", hung_n, 0);
    core_need = 1'b0; #1;
    chk("R6 hung_n need low", hung_n, 1);
    chk("R7 stall need low", core_stall, 0);
    core_need = 1'b1; ext_req_n = 1'b1; #1;
    edges(3); chk("R6 hung_n after release", hung_n, 1);
    chk("R7 stall reclaiming", core_stall, 1);
    edges(1); chk("R7 stall tail", core_stall, 1);
    chk("R7 oe on", oe_all(), ON);
    edges(1); chk("R7 stall ends", core_stall, 0);
    core_need = 1'b0; edges(2);
  endtask

  task automatic t_busy();
    xfer_busy = 1'b1; ext_req_n = 1'b0;
    edges(3); chk("R4 held 3", oe_all(), ON);
    edges(3); chk("R4 held 6", oe_all(), ON);
    chk("R4 no grant", grant_n, 1);
    xfer_busy = 1'b0;
    edges(1); chk("R4 released", oe_all(), OFF);
    edges(1); chk("R4 grant", grant_n, 0);
    ext_req_n = 1'b1; edges(5);
    chk("R4 back on", oe_all(), ON);
  endtask

  task automatic t_short_pulse();
    ext_req_n = 1'b0; edges(1); ext_req_n = 1'b1;
    edges(2); chk("R8 oe off", oe_all(), OFF);
    edges(1); chk("R8 grant", grant_n, 0);
    edges(1); chk("R8 ungrant", grant_n, 1);
    chk("R8 oe still off", oe_all(), OFF);
    edges(1); chk("R8 oe on", oe_all(), ON);
    edges(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_grant_basic();
    t_hung_stall();
    t_busy();
    t_short_pulse();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule